// File: doc/BRIEF.md
# Ethernet MAC Status and Interrupt Register

This block keeps the event flags of an Ethernet MAC that software reads through a small register bus. It records two kinds of event. The first is a change of the PHY link-status line in either direction; that line is asynchronous and is brought into the clock domain before edge detection. The second is a PAUSE-frame retry overrun: while flow control is on, a counter tracks PAUSE retransmissions and raises the flag once the count goes above a programmable limit.

Software clears a flag by writing 1 to its bit. A second register selects which flags may interrupt. One registered summary interrupt line carries the OR of the enabled flags to the controller's top-level status.

Top module: `mac_stat_irq`

## Requirements
- R1: After reset, both flags, the interrupt-enable register and `irq_o` are 0.
- R2: The status register is at byte address 0x0. Bit 4 is the retry-overrun flag and bit 2 is the link-change flag. Every other bit reads as 0. While `rd_i` is high, `rdata_o` shows the addressed register combinationally. While `rd_i` is low, `rdata_o` is 0.
- R3: A level change of `link_i` in either direction sets bit 2. The bit reads 1 after the third rising clock edge that follows the change, and not before.
- R4: With `flow_en_i` high, bit 4 is set by the `pause_retx_i` pulse that takes the retransmission count above `retry_lim_i`. That is pulse number `retry_lim_i`+1, and with a limit of 0 it is the first pulse.
- R5: The retransmission counter returns to 0 when `flow_en_i` is low, and also when bit 4 is cleared by a write. It saturates at its maximum and never wraps.
- R6: A write to address 0x0 clears each flag whose `wdata_i` bit is 1. Flags whose `wdata_i` bit is 0 are left unchanged.
- R7: If a flag's set event and its write-one-to-clear fall in the same cycle, the flag ends up set.
- R8: The interrupt-enable register is at byte address 0x4. Only bits 4 and 2 are writable. All other bits read as 0.
- R9: `irq_o` equals the OR over bits 4 and 2 of (flag AND enable), taken one clock later. A flag whose enable is 0 does not raise `irq_o`.
- R10: `pause_retx_i` pulses that arrive while `flow_en_i` is low do not count and do not set bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register byte address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data |
| link_i | input | 1 | Asynchronous PHY link status |
| pause_retx_i | input | 1 | One-cycle pulse for each PAUSE retransmission |
| flow_en_i | input | 1 | Flow-control enable |
| retry_lim_i | input | CNT_W | Retry upper limit |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench builds the block with CNT_W = 4 and the default two-stage synchroniser. The 4-bit counter puts the largest limit, 15, and the saturated counter within a few dozen pulses. The bench also uses limit 0 and limit 3. Together these limits exercise the first-pulse overrun, a mid-range limit, and the top of the counter range, including resets of the count through flow-control drop and through clearing the flag.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int REG_W     = 32;
  localparam int BIT_LINK  = 2;
  localparam int BIT_RETRY = 4;
  localparam logic [REG_W-1:0] FLAG_MASK = (REG_W'(1) << BIT_LINK) | (REG_W'(1) << BIT_RETRY);
endpackage

// File: rtl/mac_link_edge.sv
module mac_link_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  output logic chg_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], link_i};
      prev_q <= sync_q[MSB];
    end
  end

  // either-edge change on the synchronised level
  assign chg_o = sync_q[MSB] ^ prev_q;
endmodule

// File: rtl/mac_pause_retry.sv
module mac_pause_retry #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             flow_en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             over_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  // compare one bit wider so a saturated count still exceeds the top limit
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign over_o  = pulse_i && flow_en_i && (cnt_inc > {1'b0, limit_i});
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!flow_en_i || clr_i)      cnt_q <= '0;
    else if (pulse_i && cnt_q != CNT_MAX) cnt_q <= cnt_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [REG_W-1:0] en_wdata_i,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] en_o,
  output logic             irq_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_live
      logic f_q, e_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          f_q <= 1'b0;
          e_q <= 1'b0;
        end else begin
          f_q <= set_i[i] | (f_q & ~clr_i[i]); // set wins
          if (en_we_i) e_q <= en_wdata_i[i];
        end
      end
      assign flags_o[i] = f_q;
      assign en_o[i]    = e_q;
    end else begin : g_rsvd
      logic unused_bits;
      assign unused_bits = ^{set_i[i], clr_i[i], en_wdata_i[i]};
      assign flags_o[i]  = 1'b0;
      assign en_o[i]     = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flags_o & en_o);
  end
endmodule

// File: rtl/mac_stat_irq.sv
module mac_stat_irq
  import mac_stat_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                CNT_W       = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] EN_ADDR     = ADDR_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              link_i,
  input  logic              pause_retx_i,
  input  logic              flow_en_i,
  input  logic [CNT_W-1:0]  retry_lim_i,
  output logic              irq_o
);
  logic             stat_we, en_we, link_chg, retry_over, retry_clr;
  logic [CNT_W-1:0] retry_cnt;
  logic [REG_W-1:0] set_vec, clr_vec, flags, en;

  assign stat_we   = wr_i && (addr_i == STAT_ADDR);
  assign en_we     = wr_i && (addr_i == EN_ADDR);
  assign clr_vec   = stat_we ? wdata_i : '0;
  assign retry_clr = clr_vec[BIT_RETRY];

  mac_link_edge #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .link_i(link_i),
    .chg_o (link_chg)
  );

  mac_pause_retry #(.CNT_W(CNT_W)) u_retry (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (pause_retx_i),
    .flow_en_i(flow_en_i),
    .clr_i    (retry_clr),
    .limit_i  (retry_lim_i),
    .over_o   (retry_over),
    .cnt_o    (retry_cnt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_LINK]  = link_chg;
    set_vec[BIT_RETRY] = retry_over;
  end

  mac_stat_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .en_we_i   (en_we),
    .en_wdata_i(wdata_i),
    .flags_o   (flags),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == STAT_ADDR)    rdata_o = flags;
      else if (addr_i == EN_ADDR) rdata_o = en;
    end
  end
endmodule

// File: rtl/mac_stat_irq_chk.sv
module mac_stat_irq_chk
  import mac_stat_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                CNT_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(0)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              flow_en_i,
  input logic              irq_o,
  input logic [REG_W-1:0]  flags,
  input logic [REG_W-1:0]  en,
  input logic [CNT_W-1:0]  retry_cnt,
  input logic              retry_clr,
  input logic              link_chg
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> ((rdata_o & ~FLAG_MASK) == '0));

  a_r9_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags & en)) |=> irq_o);

  a_r9_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flags & en)) |=> !irq_o);

  a_r10_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flow_en_i |=> (retry_cnt == '0));

  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && !retry_clr && retry_cnt == CNT_MAX) |=> (retry_cnt == CNT_MAX));

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_chg |=> flags[BIT_LINK]);

  a_r6_w1c_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == STAT_ADDR && wdata_i[BIT_LINK] && !link_chg) |=> !flags[BIT_LINK]);
endmodule

bind mac_stat_irq mac_stat_irq_chk #(
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .flow_en_i(flow_en_i),
  .irq_o    (irq_o),
  .flags    (flags),
  .en       (en),
  .retry_cnt(retry_cnt),
  .retry_clr(retry_clr),
  .link_chg (link_chg)
);

// File: tb/sim_mac_stat_irq.sv
`timescale 1ns/1ps
module sim_mac_stat_irq;
  localparam int CNT_W = 4;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [3:0]       addr = '0;
  logic [31:0]      wdata = '0, rdata;
  logic             wr = 1'b0, rd = 1'b0, link = 1'b0, pulse = 1'b0, flow = 1'b0, irq;
  logic [CNT_W-1:0] lim = '0;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mac_stat_irq #(.ADDR_W(4), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .link_i(link), .pause_retx_i(pulse), .flow_en_i(flow),
    .retry_lim_i(lim), .irq_o(irq)
  );

  // behavioural reference
  logic        m_f2, m_f4, m_irq;
  logic [31:0] m_en;
  int          m_cnt;
  logic        hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_f2 <= 0; m_f4 <= 0; m_irq <= 0; m_en <= '0; m_cnt <= 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      logic c2, c4, chg, over;
      int   nc;
      c2   = wr && addr == 4'h0 && wdata[2];
      c4   = wr && addr == 4'h0 && wdata[4];
      chg  = hist[1] != hist[2];
      over = pulse && flow && (m_cnt + 1 > int'(lim));
      if (!flow || c4)                         nc = 0;
      else if (pulse && m_cnt < (1 << CNT_W) - 1) nc = m_cnt + 1;
      else                                     nc = m_cnt;
      m_irq <= (m_f2 && m_en[2]) || (m_f4 && m_en[4]);
      m_f2  <= chg  || (m_f2 && !c2);
      m_f4  <= over || (m_f4 && !c4);
      if (wr && addr == 4'h4) m_en <= wdata & 32'h14;
      m_cnt <= nc;
      hist.push_front(link);
      hist = hist[0:2];
    end
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    if (a == 4'h0) return {27'd0, m_f4, 1'b0, m_f2, 2'b00};
    if (a == 4'h4) return m_en;
    return '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle irq comparison (R9)
  always @(negedge clk) if (rst_n) check("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1; cyc(); wr = 1'b0; wdata = '0;
  endtask

  task automatic rchk(string tag, logic [3:0] a, logic [31:0] exp);
    addr = a; rd = 1'b1; #2;
    check(tag, rdata, exp);
    check({tag, " model"}, rdata, m_read(a));
    rd = 1'b0; #1;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pulse = 1'b1; cyc(); pulse = 1'b0; cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    rchk("R1 status reset", 4'h0, 32'h0);
    rchk("R1 enable reset", 4'h4, 32'h0);
    check("R1 irq reset", {31'd0, irq}, 32'h0);

    wreg(4'h4, 32'hFFFF_FFFF);
    rchk("R8 enable writable bits", 4'h4, 32'h14);
    rchk("R2 unmapped address", 4'h8, 32'h0);
    wreg(4'h4, 32'h4);

    // R3 rising link change
    link = 1'b1; cyc(); cyc();
    rchk("R3 not yet after two edges", 4'h0, 32'h0);
    cyc();
    rchk("R3 rise sets link flag", 4'h0, 32'h4);
    check("R9 irq one cycle late", {31'd0, irq}, 32'h0);
    cyc();
    check("R9 irq after enabled flag", {31'd0, irq}, 32'h1);
    check("R2 rdata zero without rd", rdata, 32'h0);

    wreg(4'h0, 32'hFFFF_FFEB);
    rchk("R6 write zero keeps flag", 4'h0, 32'h4);
    wreg(4'h0, 32'h4);
    rchk("R6 write one clears flag", 4'h0, 32'h0);
    cyc();
    check("R9 irq drops", {31'd0, irq}, 32'h0);

    // R3 falling edge, collides with clear (R7)
    link = 1'b0; cyc(); cyc();
    wreg(4'h0, 32'h4);
    rchk("R7 set wins over clear", 4'h0, 32'h4);
    rchk("R3 fall sets link flag", 4'h0, 32'h4);
    wreg(4'h0, 32'h4);
    cyc();

    // R4 retry overrun, limit 3
    flow = 1'b1; lim = 4'd3;
    pulses(3);
    rchk("R4 at limit no flag", 4'h0, 32'h0);
    pulses(1);
    rchk("R4 over limit sets flag", 4'h0, 32'h10);
    check("R9 masked flag no irq", {31'd0, irq}, 32'h0);
    wreg(4'h4, 32'h14);
    check("R9 irq waits a cycle", {31'd0, irq}, 32'h0);
    cyc();
    check("R9 irq after enable", {31'd0, irq}, 32'h1);

    // R5 clear resets counter
    wreg(4'h0, 32'h10);
    pulses(3);
    rchk("R5 clear restarts count", 4'h0, 32'h0);
    pulses(1);
    rchk("R5 recount sets flag", 4'h0, 32'h10);
    wreg(4'h0, 32'h10);
    pulses(2);
    flow = 1'b0; cyc(); flow = 1'b1;
    pulses(3);
    rchk("R5 flow drop restarts count", 4'h0, 32'h0);
    pulses(1);
    rchk("R5 flow drop recount sets", 4'h0, 32'h10);
    wreg(4'h0, 32'h10);

    // R10 pulses ignored while flow off
    flow = 1'b0;
    pulses(10);
    rchk("R10 no count when flow off", 4'h0, 32'h0);
    flow = 1'b1;
    pulses(3);
    rchk("R10 nothing carried over", 4'h0, 32'h0);
    wreg(4'h0, 32'h10);

    // R4 limit 0
    lim = 4'd0;
    pulses(1);
    rchk("R4 limit zero first pulse", 4'h0, 32'h10);
    wreg(4'h0, 32'h10);

    // R5 saturation at top limit
    lim = 4'd15;
    pulses(15);
    rchk("R5 max limit not exceeded", 4'h0, 32'h0);
    pulses(1);
    rchk("R5 max limit exceeded", 4'h0, 32'h10);
    pulses(5);
    rchk("R5 saturated stays set", 4'h0, 32'h10);
    wreg(4'h0, 32'h10);
    pulses(15);
    rchk("R5 after saturation clear", 4'h0, 32'h0);
    cyc(); cyc();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule